// File: doc/BRIEF.md
# Payload Input Interface for a Serial Transmit Framer

This block takes outbound payload data from terminal equipment and passes it, one bit per payload slot, to a downstream transmit framer that inserts overhead bits. The equipment may deliver payload as a single serial bit stream or as 4-bit nibbles. A static mode input chooses between the two forms. The block runs on the transmit timing reference clock, with one clock cycle per line bit time.

The framer marks each bit time as an overhead slot or a payload slot. It also pulses a frame-start input on the first slot of every frame. The block tracks the bit position within the current nibble and the nibble index within the frame. It advances both only on payload slots.

In nibble mode the block produces a one-cycle nibble strobe in the slot where it takes a new nibble. That nibble is then sent out most significant bit first over the next four payload slots. An end-of-frame flag is high while the last nibble of the frame is being handled, so the equipment can line up its next frame.

Top module: `pl_input_if`

## Requirements
- R1: With `mode_nib`=0, for every cycle with `oh_slot`=0, the next cycle shows `pay_valid`=1 and `pay_bit` equal to the `ser_in` value sampled in that cycle.
- R2: With `mode_nib`=1, `nib_in` is sampled only in a cycle where `nib_stb`=1. Its bits `nib_in[3]`, `[2]`, `[1]`, `[0]` appear on `pay_bit`, in that order, one cycle after each of the next four payload slots. The first of these slots is the strobe cycle itself.
- R3: `nib_stb` is a combinational output. It is 1 exactly in payload slots where the in-nibble bit position is 0 and `mode_nib`=1. It is never 1 in serial mode.
- R4: A cycle with `oh_slot`=1 gives `pay_valid`=0 in the next cycle and does not advance the bit position or the nibble index.
- R5: A frame holds 1176 nibbles (4704 payload bits). The nibble index counts 0 to 1175 and wraps to 0 after the fourth payload bit of nibble 1175. With the fixed overhead pattern, a full frame in nibble mode gives exactly 1176 strobes.
- R6: `eof` is a registered output. It is 1 exactly while the nibble index is 1175: from the cycle after nibble 1174's last payload bit is taken, until the cycle after nibble 1175's last payload bit is taken.
- R7: A `frame_start` pulse forces the bit position and the nibble index to 0 in the same cycle. A payload slot in that same cycle is handled as bit 0 of nibble 0. This also applies to a pulse in the middle of a frame.
- R8: The input of the unselected form (`nib_in` in serial mode, `ser_in` in nibble mode) has no effect on `pay_bit`, `pay_valid`, `nib_stb` or `eof`. A nibble-mode frame and a serial-mode frame built from the same payload bits produce identical `pay_bit` streams.
- R9: While `rst_n`=0, and in the first cycle after it is released, `pay_valid`=0 and `eof`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit timing reference, one cycle per line bit time |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_nib | input | 1 | Static form select: 0 serial, 1 nibble |
| ser_in | input | 1 | Serial payload bit from equipment |
| nib_in | input | 4 | Nibble payload from equipment, bit 3 sent first |
| oh_slot | input | 1 | Framer indication that the current slot carries overhead |
| frame_start | input | 1 | Framer pulse on the first slot of a frame |
| nib_stb | output | 1 | Nibble clock strobe; `nib_in` is taken in this cycle |
| pay_bit | output | 1 | Payload bit to the framer |
| pay_valid | output | 1 | `pay_bit` carries a payload bit this cycle |
| eof | output | 1 | The last nibble of the frame is being handled |

## Verification
The assertions check the following on every cycle:
- serial pass-through;
- the first bit sent after each strobe;
- the absence of strobes in serial mode;
- the freeze of position and valid output across overhead slots;
- the bound and wrap of the nibble index;
- the clearing effect of frame start.

Only the bench scenarios can show the rest:
- the full strobe count of a frame;
- the exact window in which `eof` is high;
- the four-bit MSB-first order of each nibble;
- a mid-frame restart;
- the equality of the payload streams from the two input forms fed the same bits.

// File: rtl/pl_input_pkg.sv
package pl_input_pkg;

    typedef enum logic {
        FORM_SERIAL = 1'b0,
        FORM_NIBBLE = 1'b1
    } in_form_e;

    localparam int DEF_NIB_W         = 4;
    localparam int DEF_NIB_PER_FRAME = 1176;

endpackage

// File: rtl/pl_frame_tracker.sv
module pl_frame_tracker #(
    parameter int NIB_W         = 4,
    parameter int NIB_PER_FRAME = 1176,
    localparam int BIT_CW       = (NIB_W > 1) ? $clog2(NIB_W) : 1,
    localparam int NIB_CW       = $clog2(NIB_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oh_slot,
    input  logic              frame_start,
    output logic              take,
    output logic [BIT_CW-1:0] bit_pos,
    output logic              eof
);

    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(NIB_W - 1);
    localparam logic [NIB_CW-1:0] LAST_NIB = NIB_CW'(NIB_PER_FRAME - 1);

    typedef struct packed {
        logic [BIT_CW-1:0] bit_pos;
        logic [NIB_CW-1:0] nib_idx;
        logic              eof;
    } trk_t;

    trk_t cur_q, nxt_d;
    logic [BIT_CW-1:0] base_bit;
    logic [NIB_CW-1:0] base_nib;

    always_comb begin
        base_bit = frame_start ? '0 : cur_q.bit_pos;
        base_nib = frame_start ? '0 : cur_q.nib_idx;
        nxt_d    = cur_q;
        nxt_d.bit_pos = base_bit;
        nxt_d.nib_idx = base_nib;
        if (!oh_slot) begin
            if (base_bit == LAST_BIT) begin
                nxt_d.bit_pos = '0;
                nxt_d.nib_idx = (base_nib == LAST_NIB) ? '0 : base_nib + 1'b1;
            end else begin
                nxt_d.bit_pos = base_bit + 1'b1;
            end
        end
        nxt_d.eof = (nxt_d.nib_idx == LAST_NIB);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign take    = !oh_slot;
    assign bit_pos = base_bit;
    assign eof     = cur_q.eof;

    AST_NIB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.nib_idx <= LAST_NIB); // R5

    AST_OH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (oh_slot && !frame_start) |=> ($stable(cur_q.bit_pos) && $stable(cur_q.nib_idx))); // R4

    AST_NIB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !oh_slot && cur_q.bit_pos == LAST_BIT && cur_q.nib_idx == LAST_NIB)
        |=> (cur_q.nib_idx == '0 && !eof)); // R5

    AST_FS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && oh_slot) |=> (cur_q.nib_idx == '0 && cur_q.bit_pos == '0)); // R7

endmodule

// File: rtl/pl_data_path.sv
module pl_data_path #(
    parameter int NIB_W   = 4,
    localparam int BIT_CW = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_nib,
    input  logic              take,
    input  logic [BIT_CW-1:0] bit_pos,
    input  logic              ser_in,
    input  logic [NIB_W-1:0]  nib_in,
    output logic              nib_stb,
    output logic              pay_bit,
    output logic              pay_valid
);

    import pl_input_pkg::*;

    typedef struct packed {
        logic [NIB_W-1:0] hold;
        logic             bit_out;
        logic             valid;
    } dp_t;

    dp_t cur_q, nxt_d;
    in_form_e          form;
    logic              stb;
    logic [BIT_CW-1:0] sel;

    always_comb begin
        form  = in_form_e'(mode_nib);
        stb   = (form == FORM_NIBBLE) && take && (bit_pos == '0);
        sel   = BIT_CW'(NIB_W - 1) - bit_pos;
        nxt_d = cur_q;
        nxt_d.valid = take;
        if (stb) nxt_d.hold = nib_in;
        if (take) begin
            if (form == FORM_NIBBLE)
                nxt_d.bit_out = stb ? nib_in[NIB_W-1] : cur_q.hold[sel];
            else
                nxt_d.bit_out = ser_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign nib_stb   = stb;
    assign pay_bit   = cur_q.bit_out;
    assign pay_valid = cur_q.valid;

    AST_SER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_nib && take) |=> (pay_valid && pay_bit == $past(ser_in))); // R1

    AST_NIB_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |=> (pay_valid && pay_bit == $past(nib_in[NIB_W-1]))); // R2

    AST_NO_STB_SER: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_nib |-> !nib_stb); // R3

    AST_OH_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !pay_valid); // R4

endmodule

// File: rtl/pl_input_if.sv
module pl_input_if #(
    parameter int NIB_W         = pl_input_pkg::DEF_NIB_W,
    parameter int NIB_PER_FRAME = pl_input_pkg::DEF_NIB_PER_FRAME
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_nib,
    input  logic             ser_in,
    input  logic [NIB_W-1:0] nib_in,
    input  logic             oh_slot,
    input  logic             frame_start,
    output logic             nib_stb,
    output logic             pay_bit,
    output logic             pay_valid,
    output logic             eof
);

    localparam int BIT_CW = (NIB_W > 1) ? $clog2(NIB_W) : 1;

    logic              take;
    logic [BIT_CW-1:0] bit_pos;

    pl_frame_tracker #(
        .NIB_W         (NIB_W),
        .NIB_PER_FRAME (NIB_PER_FRAME)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .oh_slot     (oh_slot),
        .frame_start (frame_start),
        .take        (take),
        .bit_pos     (bit_pos),
        .eof         (eof)
    );

    pl_data_path #(
        .NIB_W (NIB_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_nib  (mode_nib),
        .take      (take),
        .bit_pos   (bit_pos),
        .ser_in    (ser_in),
        .nib_in    (nib_in),
        .nib_stb   (nib_stb),
        .pay_bit   (pay_bit),
        .pay_valid (pay_valid)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!pay_valid && !eof)); // R9

endmodule

// File: tb/tb_pl_input_if.sv
module tb_pl_input_if;

    localparam int CLK_PERIOD = 10;
    localparam int NPF        = 1176;
    localparam int NBITS      = NPF * 4;
    localparam int SLOTS      = 4760;
    localparam int OH_GAP     = 85;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_nib;
    logic       ser_in;
    logic [3:0] nib_in;
    logic       oh_slot;
    logic       frame_start;
    logic       nib_stb, pay_bit, pay_valid, eof;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // bench reference state
    int   m_bit = 0, m_nib = 0;
    logic [3:0] m_hold = '0;
    logic exp_valid = 1'b0, exp_bit = 1'b0, exp_eof = 1'b0;
    int   stb_count = 0;
    bit   capture = 1'b0;
    int   cap_n = 0;
    logic sbits [NBITS];
    logic cap_a [NBITS];
    logic cap_b [NBITS];
    logic ref_first [NBITS];

    always #(CLK_PERIOD/2) clk = ~clk;

    pl_input_if dut (
        .clk(clk), .rst_n(rst_n), .mode_nib(mode_nib), .ser_in(ser_in),
        .nib_in(nib_in), .oh_slot(oh_slot), .frame_start(frame_start),
        .nib_stb(nib_stb), .pay_bit(pay_bit), .pay_valid(pay_valid), .eof(eof)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp_v, cycles);
        end
    endtask

    function automatic logic [3:0] nib_of(input int p);
        return {sbits[p], sbits[p+1], sbits[p+2], sbits[p+3]};
    endfunction

    // one slot: drive at negedge, check strobe, clock, check registered outputs
    task automatic step(input bit oh, input bit fs);
        int  b, n, p;
        bit  pay, stb;
        b   = fs ? 0 : m_bit;
        n   = fs ? 0 : m_nib;
        pay = !oh;
        p   = n * 4 + b;
        stb = mode_nib && pay && (b == 0);
        oh_slot     = oh;
        frame_start = fs;
        ser_in      = (!mode_nib && pay) ? sbits[p] : 1'($urandom);
        nib_in      = stb ? nib_of(p) : 4'($urandom);
        #1;
        chk(nib_stb == stb, "R3 nib_stb", nib_stb, stb);
        if (stb) stb_count++;
        if (pay) begin
            exp_bit = mode_nib ? (stb ? nib_in[3] : m_hold[3-b]) : ser_in;
            if (stb) m_hold = nib_in;
            if (b == 3) begin
                b = 0;
                n = (n == NPF - 1) ? 0 : n + 1;
            end else begin
                b++;
            end
        end
        exp_valid = pay;
        exp_eof   = (n == NPF - 1);
        m_bit = b;
        m_nib = n;
        @(negedge clk);
        chk(pay_valid == exp_valid, "R4 pay_valid", pay_valid, exp_valid);
        if (exp_valid)
            chk(pay_bit == exp_bit, mode_nib ? "R2 pay_bit nibble" : "R1 pay_bit serial", pay_bit, exp_bit);
        chk(eof == exp_eof, "R6 eof", eof, exp_eof);
        if (capture && pay_valid && cap_n < NBITS) begin
            if (mode_nib) cap_a[cap_n] = pay_bit;
            else          cap_b[cap_n] = pay_bit;
            cap_n++;
        end
    endtask

    task automatic full_frame(input bit mode);
        mode_nib  = mode;
        stb_count = 0;
        cap_n     = 0;
        capture   = 1'b1;
        for (int s = 0; s < SLOTS; s++) step((s % OH_GAP) == 0, s == 0);
        capture = 1'b0;
        chk(cap_n == NBITS, "R5 payload bits per frame", cap_n, NBITS);
        chk(stb_count == (mode ? NPF : 0), "R5 strobes per frame", stb_count, mode ? NPF : 0);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : main
        int mism;
        void'($urandom(32'h5eed_0c3a));
        rst_n = 1'b0; mode_nib = 1'b1; ser_in = 1'b1; nib_in = 4'hf;
        oh_slot = 1'b0; frame_start = 1'b0;
        for (int i = 0; i < NBITS; i++) sbits[i] = 1'($urandom);
        repeat (3) @(negedge clk);
        chk(pay_valid == 1'b0, "R9 reset pay_valid", pay_valid, 0);
        chk(eof == 1'b0, "R9 reset eof", eof, 0);
        oh_slot = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(pay_valid == 1'b0, "R9 after release pay_valid", pay_valid, 0);
        chk(eof == 1'b0, "R9 after release eof", eof, 0);

        // directed: nibble frames, then serial frame with the same payload bits
        full_frame(1'b1);
        for (int i = 0; i < NBITS; i++) ref_first[i] = cap_a[i];
        full_frame(1'b1);
        full_frame(1'b0);
        mism = 0;
        for (int i = 0; i < NBITS; i++) if (cap_a[i] !== cap_b[i]) mism++;
        chk(mism == 0, "R8 serial and nibble payload streams equal", mism, 0);
        mism = 0;
        for (int i = 0; i < NBITS; i++) if (cap_b[i] !== sbits[i]) mism++;
        chk(mism == 0, "R2 payload order matches source bits", mism, 0);

        // R7: mid-frame restart, then a full frame
        mode_nib = 1'b1;
        for (int s = 0; s < 1003; s++) step((s % OH_GAP) == 0, s == 0);
        step(1'b0, 1'b1); // restart on a payload slot: bit 0 of nibble 0
        for (int s = 0; s < 40; s++) step(1'b0, 1'b0);
        chk(m_nib == 10, "R7 nibble index after restart", m_nib, 10);
        full_frame(1'b1);

        // constrained random segments in both modes
        for (int seg = 0; seg < 2; seg++) begin
            mode_nib = seg[0];
            step(1'b1, 1'b1);
            for (int c = 0; c < 6000; c++)
                step(($urandom % 8) == 0, ($urandom % 3000) == 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule